// File: doc/BRIEF.md
# Unordered Memory Request Completion Tracker

This block sits on the requester side of a link that carries unordered memory traffic. It takes memory read and write requests from a local source, checks that the link and the configuration allow this kind of traffic, gives each accepted request a tag from a pool of tracked entries, and forwards it with a 33-bit transaction identifier. Writes are not finished when they leave. Every request, read or write, stays outstanding until a completion with the same identifier comes back. Completions may return in any order.

A request that breaks a precondition is refused. It is consumed, one error pulse is raised, and it takes no tag. The preconditions are: requester enable off, link not in flit mode, or a virtual channel of 0 or one not set up for this traffic. A completion that matches no outstanding entry raises an unexpected-completion pulse and changes nothing.

Both request interfaces use valid/ready. On the input, a transfer takes place in a cycle where `rq_in_valid` and `rq_in_ready` are both high. `rq_in_ready` is always high for a request that will be refused. For a legal request it is high only when a tag is free and the output slot is empty or is being drained. The output holds its identifier, type and channel stable while `rq_out_valid` is high and `rq_out_ready` is low. Completions are taken every cycle that `cp_valid` is high, with no back-pressure.

Top module: `uio_cpl_tracker`

## Requirements
- R1: The outgoing identifier is {TC[2:0] in bits 32:30, requester ID[15:0] in bits 29:14, tag[13:0] in bits 13:0}. The tag is the entry index, zero-extended to 14 bits.
- R2: A legal request that finds a free entry is accepted in the same cycle. It appears on the output one cycle later with the lowest-numbered free tag, its type, and its channel.
- R3: While `rq_out_valid` is high and `rq_out_ready` is low, the output contents stay stable and no legal request is accepted.
- R4: With `cfg_req_en` low, a request is consumed and produces no output. `err_refused` pulses for one cycle in the cycle after, and no tag is used.
- R5: With `cfg_flit_mode` low, a request is refused in the same way as R4.
- R6: A request on virtual channel 0, or on a channel whose bit in `cfg_uio_vc_mask` is clear, is refused in the same way as R4. No request ever leaves on channel 0.
- R7: A write stays outstanding until its completion arrives. A second completion for the same identifier is then unexpected.
- R8: A completion whose identifier matches an outstanding entry (same TC, requester ID and tag) frees that entry. One cycle later it gives a one-cycle `rt_valid` pulse with the tag and with `rt_is_write` showing the original request type.
- R9: Completions are matched in any order relative to the order of the requests.
- R10: A completion with no matching outstanding entry gives one `err_unexpected` pulse one cycle later and no retire pulse. It leaves every entry as it was.
- R11: When all entries are in use, a legal request sees `rq_in_ready` low. Once an entry retires, its tag can be handed out again.
- R12: A refused request is consumed even when every entry is in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req_en | input | 1 | Requester enable |
| cfg_flit_mode | input | 1 | Link is in flit mode |
| cfg_uio_vc_mask | input | 4 | One bit per virtual channel set up for unordered traffic |
| cfg_req_id | input | 16 | Own requester ID |
| rq_in_valid | input | 1 | Request present |
| rq_in_ready | output | 1 | Request taken this cycle |
| rq_in_is_write | input | 1 | 1 = write, 0 = read |
| rq_in_tc | input | 3 | Traffic class |
| rq_in_vc | input | 2 | Virtual channel |
| rq_out_valid | output | 1 | Forwarded request present |
| rq_out_ready | input | 1 | Downstream takes the request |
| rq_out_is_write | output | 1 | Forwarded request type |
| rq_out_vc | output | 2 | Forwarded channel |
| rq_out_txid | output | 33 | Transaction identifier |
| cp_valid | input | 1 | Completion present |
| cp_txid | input | 33 | Completion identifier |
| rt_valid | output | 1 | Retire pulse |
| rt_tag | output | 14 | Retired tag |
| rt_is_write | output | 1 | Retired request was a write |
| err_refused | output | 1 | Refused-request pulse |
| err_unexpected | output | 1 | Unmatched-completion pulse |

## Verification
The hardest case to reach is a full pool. The stimulus fills it by issuing sixteen legal requests and returning no completions. It then shows that a further legal request is stalled while a refused one still goes through. After that it frees entries out of order and checks that the lowest freed tag is handed out next. A completion that almost matches, with the right tag but the wrong class or requester ID, is sent while that entry is outstanding. The entry's later normal retire shows that the near-match changed nothing.

// File: rtl/uio_trk_pkg.sv
package uio_trk_pkg;
  localparam int TAG_W  = 14;
  localparam int RID_W  = 16;
  localparam int TC_W   = 3;
  localparam int TXID_W = TC_W + RID_W + TAG_W;

  typedef struct packed {
    logic [TC_W-1:0]  tc;
    logic [RID_W-1:0] rid;
    logic [TAG_W-1:0] tag;
  } txid_t;

  function automatic txid_t make_txid(input logic [TC_W-1:0] tc,
                                      input logic [RID_W-1:0] rid,
                                      input logic [TAG_W-1:0] tag);
    txid_t t;
    t.tc  = tc;
    t.rid = rid;
    t.tag = tag;
    return t;
  endfunction
endpackage

// File: rtl/uio_req_gate.sv
module uio_req_gate #(
  parameter int NUM_VC = 4,
  localparam int VC_W = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic              cfg_req_en,
  input  logic              cfg_flit_mode,
  input  logic [NUM_VC-1:0] cfg_uio_vc_mask,
  input  logic [VC_W-1:0]   vc,
  output logic              legal
);
  logic vc_ok;

  always_comb begin
    vc_ok = 1'b0;
    for (int i = 1; i < NUM_VC; i++) begin
      if (vc == VC_W'(i) && cfg_uio_vc_mask[i]) vc_ok = 1'b1;
    end
  end

  assign legal = cfg_req_en & cfg_flit_mode & vc_ok;
endmodule

// File: rtl/uio_tag_pool.sv
module uio_tag_pool
  import uio_trk_pkg::*;
#(
  parameter int NUM_ENT = 16,
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RID_W-1:0]  cfg_req_id,
  input  logic              alloc_en,
  input  logic [TC_W-1:0]   alloc_tc,
  input  logic              alloc_wr,
  output logic              has_free,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              cp_valid,
  input  txid_t             cp_txid,
  output logic              rt_valid,
  output logic [TAG_W-1:0]  rt_tag,
  output logic              rt_is_write,
  output logic              unexp
);
  logic [NUM_ENT-1:0] busy;
  logic [TC_W-1:0]    tc_mem [NUM_ENT];
  logic [NUM_ENT-1:0] wr_mem;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic               tag_in_range;

  // lowest free entry wins
  always_comb begin
    has_free  = 1'b0;
    alloc_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        has_free  = 1'b1;
        alloc_idx = IDX_W'(i);
      end
    end
  end

  assign tag_in_range = (cp_txid.tag < TAG_W'(NUM_ENT));
  assign hit_idx      = cp_txid.tag[IDX_W-1:0];
  assign hit = tag_in_range && busy[hit_idx] &&
               (tc_mem[hit_idx] == cp_txid.tc) && (cp_txid.rid == cfg_req_id);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= '0;
      wr_mem      <= '0;
      rt_valid    <= 1'b0;
      rt_tag      <= '0;
      rt_is_write <= 1'b0;
      unexp       <= 1'b0;
    end else begin
      rt_valid <= cp_valid && hit;
      unexp    <= cp_valid && !hit;
      if (cp_valid && hit) begin
        busy[hit_idx] <= 1'b0;
        rt_tag        <= TAG_W'(hit_idx);
        rt_is_write   <= wr_mem[hit_idx];
      end
      if (alloc_en) begin
        busy[alloc_idx]   <= 1'b1;
        wr_mem[alloc_idx] <= alloc_wr;
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_tc
      always_ff @(posedge clk) begin
        if (alloc_en && alloc_idx == IDX_W'(g)) tc_mem[g] <= alloc_tc;
      end
    end
  endgenerate

  AST_ALLOC_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> has_free && !busy[alloc_idx]); // R11
  AST_HIT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_valid && hit) |=> rt_valid && !unexp && !busy[$past(hit_idx)]); // R8
  AST_MISS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_valid && !hit && !alloc_en) |=> unexp && !rt_valid && $stable(busy)); // R10
endmodule

// File: rtl/uio_req_out.sv
module uio_req_out
  import uio_trk_pkg::*;
#(
  parameter int VC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  txid_t            in_txid,
  input  logic             in_wr,
  input  logic [VC_W-1:0]  in_vc,
  output logic             space,
  output logic             out_valid,
  input  logic             out_ready,
  output txid_t            out_txid,
  output logic             out_wr,
  output logic [VC_W-1:0]  out_vc
);
  assign space = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_txid  <= '0;
      out_wr    <= 1'b0;
      out_vc    <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_txid  <= in_txid;
      out_wr    <= in_wr;
      out_vc    <= in_vc;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_UNDER_BP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_txid) && $stable(out_vc)); // R3
  AST_NO_LOAD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !load); // R3
endmodule

// File: rtl/uio_cpl_tracker.sv
module uio_cpl_tracker
  import uio_trk_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int NUM_VC  = 4,
  localparam int VC_W = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_req_en,
  input  logic              cfg_flit_mode,
  input  logic [NUM_VC-1:0] cfg_uio_vc_mask,
  input  logic [RID_W-1:0]  cfg_req_id,
  input  logic              rq_in_valid,
  output logic              rq_in_ready,
  input  logic              rq_in_is_write,
  input  logic [TC_W-1:0]   rq_in_tc,
  input  logic [VC_W-1:0]   rq_in_vc,
  output logic              rq_out_valid,
  input  logic              rq_out_ready,
  output logic              rq_out_is_write,
  output logic [VC_W-1:0]   rq_out_vc,
  output logic [TXID_W-1:0] rq_out_txid,
  input  logic              cp_valid,
  input  logic [TXID_W-1:0] cp_txid,
  output logic              rt_valid,
  output logic [TAG_W-1:0]  rt_tag,
  output logic              rt_is_write,
  output logic              err_refused,
  output logic              err_unexpected
);
  logic             legal;
  logic             has_free;
  logic             space;
  logic             accept;
  logic [IDX_W-1:0] alloc_idx;
  txid_t            new_txid;
  txid_t            out_txid_s;

  uio_req_gate #(.NUM_VC(NUM_VC)) u_gate (
    .cfg_req_en      (cfg_req_en),
    .cfg_flit_mode   (cfg_flit_mode),
    .cfg_uio_vc_mask (cfg_uio_vc_mask),
    .vc              (rq_in_vc),
    .legal           (legal)
  );

  assign rq_in_ready = !legal || (has_free && space);
  assign accept      = rq_in_valid && legal && has_free && space;
  assign new_txid    = make_txid(rq_in_tc, cfg_req_id, TAG_W'(alloc_idx));

  uio_tag_pool #(.NUM_ENT(NUM_ENT)) u_pool (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_req_id  (cfg_req_id),
    .alloc_en    (accept),
    .alloc_tc    (rq_in_tc),
    .alloc_wr    (rq_in_is_write),
    .has_free    (has_free),
    .alloc_idx   (alloc_idx),
    .cp_valid    (cp_valid),
    .cp_txid     (txid_t'(cp_txid)),
    .rt_valid    (rt_valid),
    .rt_tag      (rt_tag),
    .rt_is_write (rt_is_write),
    .unexp       (err_unexpected)
  );

  uio_req_out #(.VC_W(VC_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .in_txid   (new_txid),
    .in_wr     (rq_in_is_write),
    .in_vc     (rq_in_vc),
    .space     (space),
    .out_valid (rq_out_valid),
    .out_ready (rq_out_ready),
    .out_txid  (out_txid_s),
    .out_wr    (rq_out_is_write),
    .out_vc    (rq_out_vc)
  );
  assign rq_out_txid = out_txid_s;

  always_ff @(posedge clk) begin
    if (!rst_n) err_refused <= 1'b0;
    else        err_refused <= rq_in_valid && !legal;
  end

  AST_NO_VC0_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    rq_out_valid |-> rq_out_vc != '0); // R6
  AST_REFUSE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_in_valid && !legal) |-> rq_in_ready ##1 err_refused); // R4
  AST_ERR_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(rt_valid && err_unexpected)); // R10
endmodule

// File: tb/uio_cpl_tracker_tb.sv
module uio_cpl_tracker_tb;
  localparam logic [15:0] RID = 16'hA5C3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_req_en = 1'b1, cfg_flit_mode = 1'b1;
  logic [3:0]  cfg_uio_vc_mask = 4'b1010;
  logic        rq_in_valid = 1'b0, rq_in_is_write = 1'b0;
  logic [2:0]  rq_in_tc = '0;
  logic [1:0]  rq_in_vc = 2'd1;
  logic        rq_in_ready, rq_out_valid, rq_out_is_write;
  logic        rq_out_ready = 1'b1;
  logic [1:0]  rq_out_vc;
  logic [32:0] rq_out_txid;
  logic        cp_valid = 1'b0;
  logic [32:0] cp_txid = '0;
  logic        rt_valid, rt_is_write, err_refused, err_unexpected;
  logic [13:0] rt_tag;

  int n_chk = 0, n_fail = 0;
  logic [15:0] busy_m = '0;
  logic [15:0] wr_m = '0;
  logic [2:0]  tc_m [16];

  always #2.5 clk = ~clk;

  uio_cpl_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_req_en(cfg_req_en), .cfg_flit_mode(cfg_flit_mode),
    .cfg_uio_vc_mask(cfg_uio_vc_mask), .cfg_req_id(RID),
    .rq_in_valid(rq_in_valid), .rq_in_ready(rq_in_ready), .rq_in_is_write(rq_in_is_write),
    .rq_in_tc(rq_in_tc), .rq_in_vc(rq_in_vc),
    .rq_out_valid(rq_out_valid), .rq_out_ready(rq_out_ready), .rq_out_is_write(rq_out_is_write),
    .rq_out_vc(rq_out_vc), .rq_out_txid(rq_out_txid),
    .cp_valid(cp_valid), .cp_txid(cp_txid),
    .rt_valid(rt_valid), .rt_tag(rt_tag), .rt_is_write(rt_is_write),
    .err_refused(err_refused), .err_unexpected(err_unexpected)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < 16; i++) if (!busy_m[i]) return i;
    return -1;
  endfunction

  // one request; legal selects the expected outcome
  task automatic send(input bit en, input bit flit, input logic [1:0] vc,
                      input logic [2:0] tc, input bit wr, input bit legal, input string rq);
    int t;
    t = lowest_free();
    @(negedge clk);
    cfg_req_en = en; cfg_flit_mode = flit;
    rq_in_vc = vc; rq_in_tc = tc; rq_in_is_write = wr; rq_in_valid = 1'b1;
    #1 chk({rq, " in_ready"}, 64'(rq_in_ready), 64'd1);
    @(negedge clk);
    rq_in_valid = 1'b0;
    chk({rq, " err_refused"}, 64'(err_refused), 64'(!legal));
    chk({rq, " out_valid"}, 64'(rq_out_valid), 64'(legal));
    if (legal) begin
      chk({rq, " R1 txid"}, 64'(rq_out_txid), 64'({tc, RID, 14'(t)}));
      chk({rq, " type/vc"}, 64'({rq_out_is_write, rq_out_vc}), 64'({wr, vc}));
      busy_m[t] = 1'b1; wr_m[t] = wr; tc_m[t] = tc;
    end
    cfg_req_en = 1'b1; cfg_flit_mode = 1'b1;
  endtask

  task automatic cpl(input logic [2:0] tc, input logic [15:0] rid, input logic [13:0] tag,
                     input string rq);
    bit hit;
    hit = (tag < 16) && busy_m[tag[3:0]] && tc_m[tag[3:0]] == tc && rid == RID;
    @(negedge clk);
    cp_valid = 1'b1; cp_txid = {tc, rid, tag};
    @(negedge clk);
    cp_valid = 1'b0;
    chk({rq, " rt_valid"}, 64'(rt_valid), 64'(hit));
    chk({rq, " err_unexpected"}, 64'(err_unexpected), 64'(!hit));
    if (hit) begin
      chk({rq, " rt_tag/type"}, 64'({rt_tag, rt_is_write}), 64'({tag, wr_m[tag[3:0]]}));
      busy_m[tag[3:0]] = 1'b0;
    end
  endtask

  // {en, flit, vc[1:0], tc[2:0], wr, legal}
  localparam logic [8:0] VEC [12] = '{
    {1'b1, 1'b1, 2'd1, 3'd0, 1'b0, 1'b1},
    {1'b1, 1'b1, 2'd3, 3'd5, 1'b1, 1'b1},
    {1'b0, 1'b1, 2'd1, 3'd2, 1'b0, 1'b0},
    {1'b1, 1'b0, 2'd3, 3'd1, 1'b1, 1'b0},
    {1'b1, 1'b1, 2'd0, 3'd0, 1'b0, 1'b0},
    {1'b1, 1'b1, 2'd2, 3'd3, 1'b1, 1'b0},
    {1'b1, 1'b1, 2'd1, 3'd7, 1'b1, 1'b1},
    {1'b1, 1'b1, 2'd3, 3'd4, 1'b0, 1'b1},
    {1'b0, 1'b0, 2'd0, 3'd6, 1'b1, 1'b0},
    {1'b1, 1'b1, 2'd1, 3'd3, 1'b1, 1'b1},
    {1'b0, 1'b1, 2'd3, 3'd1, 1'b1, 1'b0},
    {1'b1, 1'b1, 2'd3, 3'd2, 1'b0, 1'b1}
  };

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [32:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset outputs", 64'({rq_out_valid, rt_valid, err_refused, err_unexpected}), 64'd0);

    // table walk: R2 R4 R5 R6 R8
    foreach (VEC[i]) begin
      send(VEC[i][8], VEC[i][7], VEC[i][6:5], VEC[i][4:2], VEC[i][1], VEC[i][0], "R2/R4/R5/R6 vec");
      if (VEC[i][0]) cpl(VEC[i][4:2], RID, 14'd0, "R8 vec retire");
    end

    // fill the pool: tags 0..15 in order (R2)
    for (int i = 0; i < 16; i++) send(1, 1, 2'd1, 3'(i), i[0], 1'b1, "R2 fill");
    @(negedge clk);
    rq_in_vc = 2'd3; rq_in_valid = 1'b1;
    #1 chk("R11 stall when full", 64'(rq_in_ready), 64'd0);
    @(negedge clk);
    chk("R11 no output when full", 64'(rq_out_valid), 64'd0);
    rq_in_valid = 1'b0;
    send(1, 1, 2'd0, 3'd1, 1'b0, 1'b0, "R12 refused while full");

    // near-miss completions: wrong TC, wrong RID, tag out of range (R10)
    cpl(3'd4, RID, 14'd3, "R10 wrong tc");
    cpl(3'd3, 16'h1234, 14'd3, "R10 wrong rid");
    cpl(3'd0, RID, 14'd20, "R10 tag out of range");
    // out of order retires (R9); tag 3 still intact after near misses (R10)
    cpl(3'd9 % 8, RID, 14'd9, "R9 retire 9");
    cpl(3'd3, RID, 14'd3, "R10 entry intact, R9 retire 3");
    cpl(3'd2, RID, 14'd2, "R9 retire 2");
    // lowest freed tag reused (R11)
    send(1, 1, 2'd3, 3'd6, 1'b1, 1'b1, "R11 reuse lowest tag 2");
    // write retires with type, then a repeat is unexpected (R7)
    cpl(3'd6, RID, 14'd2, "R7 write retire");
    cpl(3'd6, RID, 14'd2, "R7 second completion");

    // back-pressure (R3)
    rq_out_ready = 1'b0;
    send(1, 1, 2'd1, 3'd5, 1'b0, 1'b1, "R3 first under bp");
    held = rq_out_txid;
    @(negedge clk);
    rq_in_vc = 2'd1; rq_in_tc = 3'd7; rq_in_is_write = 1'b1; rq_in_valid = 1'b1;
    #1 chk("R3 in_ready low while out full", 64'(rq_in_ready), 64'd0);
    @(negedge clk);
    chk("R3 out held", 64'({rq_out_valid, rq_out_txid}), 64'({1'b1, held}));
    rq_out_ready = 1'b1;
    #1 chk("R3 in_ready once drained", 64'(rq_in_ready), 64'd1);
    @(negedge clk);
    rq_in_valid = 1'b0;
    chk("R3 second out", 64'({rq_out_valid, rq_out_txid}), 64'({1'b1, 3'd7, RID, 14'd3}));
    @(negedge clk);
    chk("R3 out drained", 64'(rq_out_valid), 64'd0);

    finish_run();
  end
endmodule